// File: doc/BRIEF.md
# Integer Execution Unit with Selective Overflow Trap

This block is the purely combinational integer datapath of a load-store RISC pipeline's execute stage. Each cycle it takes two register operands, a 16-bit immediate field, a 5-bit constant shift field and a 5-bit operation code. From these it forms a 32-bit result and an overflow-trap flag.

The operations are:
- add and subtract, each in a trapping and a non-trapping form;
- bitwise logic on registers or on an immediate;
- signed and unsigned less-than compares that yield 0 or 1;
- upper-immediate load;
- shifts by a constant field or by a register.

The unit extends the immediate itself: sign extension for arithmetic and compare forms, zero extension for logical forms. Only the trapping arithmetic forms can raise the overflow flag. The pipeline around the unit decides what to do with the flag. The unit has no clock, no state and no handshake: the result and flag follow the inputs.

Top module: `int_alu`

## Requirements
- R1: `op_i` encodings are: 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 ADDI, 5 ADDIU, 6 AND, 7 OR, 8 XOR, 9 NOR, 10 ANDI, 11 ORI, 12 XORI, 13 SLT, 14 SLTU, 15 SLTI, 16 SLTIU, 17 LUI, 18 SLL, 19 SRL, 20 SRA, 21 SLLV, 22 SRLV, 23 SRAV. Codes 24 to 31 are unassigned.
- R2: ADD and ADDU give `a_i + b_i` modulo 2^32, and SUB and SUBU give `a_i - b_i` modulo 2^32. The result is written even when the flag is raised.
- R3: `ovf_o` is 1 for ADD, SUB and ADDI exactly when the true signed result does not fit in 32 bits.
- R4: `ovf_o` is 0 for every other code, including ADDU, SUBU and ADDIU, all logic, compare and shift codes, and unassigned codes.
- R5: ADDI, ADDIU, SLTI and SLTIU use `a_i` and the immediate sign-extended from bit 15 to 32 bits.
- R6: ANDI, ORI and XORI combine `a_i` with the immediate zero-extended to 32 bits.
- R7: SLT/SLTI give 1 if `a_i` is below the second operand as two's complement numbers, else 0. SLTU/SLTIU compare them as unsigned numbers. So 0xFFFFFFFF < 1 holds signed but not unsigned.
- R8: LUI gives the immediate in bits 31:16 and zeros in bits 15:0.
- R9: SLL, SRL and SRA shift `b_i` by `shamt_i`. SLL and SRL fill with zeros, and SRA fills with copies of bit 31 of `b_i`.
- R10: SLLV, SRLV and SRAV shift `b_i` by bits 4:0 of `a_i`; the upper bits of `a_i` are ignored. Fill follows R9.
- R11: AND, OR, XOR and NOR combine `a_i` and `b_i` bitwise; NOR is the complement of the OR.
- R12: unassigned codes give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First register operand; low 5 bits also give the variable shift amount |
| b_i | input | 32 | Second register operand; data for all shifts |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Constant shift amount |
| op_i | input | 5 | Operation code (R1) |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed-overflow trap request |

## Verification
The embedded assertions assume every input carries a known value. They are skipped while `op_i` is unknown, and the bench drives all inputs on every step before any output is read. They also assume that all 32 codes may appear, so the unassigned range is checked rather than excluded, and the bench sweeps every code.

Operand values are chosen at the sign boundaries (0, 1, the largest positive, the most negative, all-ones) together with mixed patterns. Immediates straddle bit 15, and register shift amounts carry stray upper bits, so that overflow, extension and shift-masking corners all occur within the sweep.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
    OP_XOR   = 5'd8,  OP_NOR   = 5'd9,  OP_ANDI  = 5'd10, OP_ORI   = 5'd11,
    OP_XORI  = 5'd12, OP_SLT   = 5'd13, OP_SLTU  = 5'd14, OP_SLTI  = 5'd15,
    OP_SLTIU = 5'd16, OP_LUI   = 5'd17, OP_SLL   = 5'd18, OP_SRL   = 5'd19,
    OP_SRA   = 5'd20, OP_SLLV  = 5'd21, OP_SRLV  = 5'd22, OP_SRAV  = 5'd23
  } alu_op_e;

  typedef enum logic [3:0] {
    SEL_ARITH, SEL_AND, SEL_OR, SEL_XOR, SEL_NOR,
    SEL_LTS, SEL_LTU, SEL_UPPER, SEL_SHIFT, SEL_ZERO
  } res_sel_e;

  typedef enum logic [1:0] {
    SH_LEFT, SH_RIGHT_LOG, SH_RIGHT_ARITH
  } shift_kind_e;

  typedef struct packed {
    res_sel_e    sel;
    logic        use_imm;
    logic        imm_signed;
    logic        negate_b;
    logic        trap_en;
    shift_kind_e shift_kind;
    logic        shift_by_reg;
  } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import int_alu_pkg::*;
(
  input  logic [4:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{sel: SEL_ZERO, use_imm: 1'b0, imm_signed: 1'b0, negate_b: 1'b0,
               trap_en: 1'b0, shift_kind: SH_LEFT, shift_by_reg: 1'b0};
    case (op_i)
      OP_ADD:   begin ctrl_o.sel = SEL_ARITH; ctrl_o.trap_en = 1'b1; end
      OP_ADDU:  ctrl_o.sel = SEL_ARITH;
      OP_SUB:   begin ctrl_o.sel = SEL_ARITH; ctrl_o.negate_b = 1'b1; ctrl_o.trap_en = 1'b1; end
      OP_SUBU:  begin ctrl_o.sel = SEL_ARITH; ctrl_o.negate_b = 1'b1; end
      OP_ADDI:  begin
        ctrl_o.sel = SEL_ARITH; ctrl_o.use_imm = 1'b1;
        ctrl_o.imm_signed = 1'b1; ctrl_o.trap_en = 1'b1;
      end
      OP_ADDIU: begin ctrl_o.sel = SEL_ARITH; ctrl_o.use_imm = 1'b1; ctrl_o.imm_signed = 1'b1; end
      OP_AND:   ctrl_o.sel = SEL_AND;
      OP_OR:    ctrl_o.sel = SEL_OR;
      OP_XOR:   ctrl_o.sel = SEL_XOR;
      OP_NOR:   ctrl_o.sel = SEL_NOR;
      OP_ANDI:  begin ctrl_o.sel = SEL_AND; ctrl_o.use_imm = 1'b1; end
      OP_ORI:   begin ctrl_o.sel = SEL_OR;  ctrl_o.use_imm = 1'b1; end
      OP_XORI:  begin ctrl_o.sel = SEL_XOR; ctrl_o.use_imm = 1'b1; end
      OP_SLT:   begin ctrl_o.sel = SEL_LTS; ctrl_o.negate_b = 1'b1; end
      OP_SLTU:  begin ctrl_o.sel = SEL_LTU; ctrl_o.negate_b = 1'b1; end
      OP_SLTI:  begin
        ctrl_o.sel = SEL_LTS; ctrl_o.negate_b = 1'b1;
        ctrl_o.use_imm = 1'b1; ctrl_o.imm_signed = 1'b1;
      end
      OP_SLTIU: begin
        ctrl_o.sel = SEL_LTU; ctrl_o.negate_b = 1'b1;
        ctrl_o.use_imm = 1'b1; ctrl_o.imm_signed = 1'b1;
      end
      OP_LUI:   ctrl_o.sel = SEL_UPPER;
      OP_SLL:   begin ctrl_o.sel = SEL_SHIFT; ctrl_o.shift_kind = SH_LEFT; end
      OP_SRL:   begin ctrl_o.sel = SEL_SHIFT; ctrl_o.shift_kind = SH_RIGHT_LOG; end
      OP_SRA:   begin ctrl_o.sel = SEL_SHIFT; ctrl_o.shift_kind = SH_RIGHT_ARITH; end
      OP_SLLV:  begin ctrl_o.sel = SEL_SHIFT; ctrl_o.shift_kind = SH_LEFT; ctrl_o.shift_by_reg = 1'b1; end
      OP_SRLV:  begin ctrl_o.sel = SEL_SHIFT; ctrl_o.shift_kind = SH_RIGHT_LOG; ctrl_o.shift_by_reg = 1'b1; end
      OP_SRAV:  begin ctrl_o.sel = SEL_SHIFT; ctrl_o.shift_kind = SH_RIGHT_ARITH; ctrl_o.shift_by_reg = 1'b1; end
      default:  ctrl_o.sel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/int_alu_immext.sv
module int_alu_immext #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             signed_i,
  output logic [XLEN-1:0]  imm_ext_o
);

  localparam int PAD_W = XLEN - IMM_W;

  logic fill;
  assign fill      = signed_i & imm_i[IMM_W-1];
  assign imm_ext_o = {{PAD_W{fill}}, imm_i};

  // Guards on the upper pad: zero for logical forms, sign copies for arithmetic
  always_comb begin
    if (!$isunknown({signed_i, imm_i})) begin
      if (!signed_i)
        assert_logic_zext_R6: assert (imm_ext_o[XLEN-1:IMM_W] == '0)
          else $error("logical immediate not zero-extended");
      else
        assert_arith_sext_R5: assert (imm_ext_o[XLEN-1:IMM_W] == (imm_i[IMM_W-1] ? {PAD_W{1'b1}} : {PAD_W{1'b0}}))
          else $error("arithmetic immediate not sign-extended");
    end
  end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            negate_b_i,
  input  logic            trap_en_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_signed_o,
  output logic            lt_unsigned_o,
  output logic            ovf_o
);

  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic            carry;
  logic            raw_ovf;

  assign b_eff           = negate_b_i ? ~b_i : b_i;
  assign {carry, sum_o}  = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, negate_b_i};
  assign raw_ovf         = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  assign lt_signed_o     = sum_o[MSB] ^ raw_ovf;
  assign lt_unsigned_o   = ~carry;
  assign ovf_o           = trap_en_i & raw_ovf;

  always_comb begin
    if (!$isunknown({trap_en_i, negate_b_i})) begin
      if (!trap_en_i)
        assert_no_overflow_R4: assert (!ovf_o)
          else $error("overflow raised for a non-trapping form");
      // a true flag means operands of equal sign and a flipped result sign
      if (ovf_o && !negate_b_i)
        assert_add_ovf_signs_R3: assert ((a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != b_i[MSB]))
          else $error("addition overflow with mismatched signs");
    end
  end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
  import int_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  shift_kind_e     kind_i,
  output logic [XLEN-1:0] data_o
);

  localparam int MSB = XLEN - 1;

  logic            to_left;
  logic            fill;
  logic [XLEN-1:0] stage [SHW+1];
  logic [XLEN-1:0] staged_in;

  assign to_left = (kind_i == SH_LEFT);
  assign fill    = (kind_i == SH_RIGHT_ARITH) & data_i[MSB];

  // Left shifts reuse the right-shift network on bit-reversed data
  always_comb begin
    for (int i = 0; i < XLEN; i++)
      staged_in[i] = to_left ? data_i[MSB-i] : data_i[i];
  end

  assign stage[0] = staged_in;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][XLEN-1:STEP]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < XLEN; i++)
      data_o[i] = to_left ? stage[SHW][MSB-i] : stage[SHW][i];
  end

  always_comb begin
    if (!$isunknown({kind_i, amt_i, data_i})) begin
      if (kind_i == SH_RIGHT_ARITH && amt_i != '0)
        assert_sra_fill_R9: assert (data_o[MSB] == data_i[MSB])
          else $error("arithmetic right shift lost the sign fill");
      if (kind_i == SH_RIGHT_LOG && amt_i != '0)
        assert_srl_fill_R9: assert (!data_o[MSB])
          else $error("logical right shift filled with ones");
      if (kind_i == SH_LEFT && amt_i != '0)
        assert_sll_fill_R9: assert (!data_o[0])
          else $error("left shift filled with ones");
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(XLEN),
  parameter int OP_W  = 5
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ovf_o
);

  localparam int LOW_W = XLEN - IMM_W;

  alu_ctrl_t       ctrl;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] sum;
  logic            lt_s;
  logic            lt_u;
  logic            add_ovf;
  logic [SHW-1:0]  shift_amt;
  logic [XLEN-1:0] shifted;

  int_alu_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  int_alu_immext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_immext (
    .imm_i     (imm_i),
    .signed_i  (ctrl.imm_signed),
    .imm_ext_o (imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : b_i;

  int_alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i           (a_i),
    .b_i           (opnd_b),
    .negate_b_i    (ctrl.negate_b),
    .trap_en_i     (ctrl.trap_en),
    .sum_o         (sum),
    .lt_signed_o   (lt_s),
    .lt_unsigned_o (lt_u),
    .ovf_o         (add_ovf)
  );

  assign shift_amt = ctrl.shift_by_reg ? a_i[SHW-1:0] : shamt_i;

  int_alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .data_i (b_i),
    .amt_i  (shift_amt),
    .kind_i (ctrl.shift_kind),
    .data_o (shifted)
  );

  always_comb begin
    case (ctrl.sel)
      SEL_ARITH: result_o = sum;
      SEL_AND:   result_o = a_i & opnd_b;
      SEL_OR:    result_o = a_i | opnd_b;
      SEL_XOR:   result_o = a_i ^ opnd_b;
      SEL_NOR:   result_o = ~(a_i | opnd_b);
      SEL_LTS:   result_o = {{(XLEN-1){1'b0}}, lt_s};
      SEL_LTU:   result_o = {{(XLEN-1){1'b0}}, lt_u};
      SEL_UPPER: result_o = {imm_i, {LOW_W{1'b0}}};
      SEL_SHIFT: result_o = shifted;
      default:   result_o = '0;
    endcase
  end

  assign ovf_o = add_ovf;

  always_comb begin
    if (!$isunknown(op_i)) begin
      if (ovf_o)
        assert_ovf_only_trap_ops_R4: assert (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_ADDI)
          else $error("overflow flag on a code that never traps");
      if (op_i == OP_SLT || op_i == OP_SLTU || op_i == OP_SLTI || op_i == OP_SLTIU)
        assert_set_is_bool_R7: assert (result_o[XLEN-1:1] == '0)
          else $error("compare result wider than one bit");
      if (op_i == OP_LUI)
        assert_lui_low_clear_R8: assert (result_o[LOW_W-1:0] == '0 && result_o[XLEN-1:LOW_W] == imm_i)
          else $error("upper-immediate layout wrong");
      if (op_i > OP_SRAV)
        assert_unassigned_zero_R12: assert (result_o == '0 && !ovf_o)
          else $error("unassigned code produced output");
    end
  end

endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [4:0]  op;
  logic [31:0] result;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  int_alu u_dut (
    .a_i      (a),
    .b_i      (b),
    .imm_i    (imm),
    .shamt_i  (shamt),
    .op_i     (op),
    .result_o (result),
    .ovf_o    (ovf)
  );

  logic [31:0] av [8];
  logic [31:0] bv [8];
  logic [15:0] iv [6];
  logic [4:0]  sv [4];

  // Requirement owning the result of each code (R1 encodings)
  function automatic string res_tag(input int o);
    if (o <= 3)  return "R2";
    if (o <= 5)  return "R5";
    if (o <= 9)  return "R11";
    if (o <= 12) return "R6";
    if (o <= 14) return "R7";
    if (o <= 16) return "R5";
    if (o == 17) return "R8";
    if (o <= 20) return "R9";
    if (o <= 23) return "R10";
    return "R12";
  endfunction

  task automatic model(input int o, input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] im, input logic [4:0] sh,
                       output logic [31:0] r, output logic v);
    longint sx, sy, wide;
    logic [31:0] se, ze;
    int n;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    se = {{16{im[15]}}, im};
    ze = {16'h0, im};
    v  = 1'b0;
    r  = 32'h0;
    case (o)
      0, 1: begin r = x + y; wide = sx + sy; v = (o == 0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      2, 3: begin r = x - y; wide = sx - sy; v = (o == 2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
      4, 5: begin
        r = x + se; wide = sx + longint'($signed(se));
        v = (o == 4) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      6:  r = x & y;
      7:  r = x | y;
      8:  r = x ^ y;
      9:  r = ~(x | y);
      10: r = x & ze;
      11: r = x | ze;
      12: r = x ^ ze;
      13: r = {31'h0, sx < sy};
      14: r = {31'h0, x < y};
      15: r = {31'h0, sx < longint'($signed(se))};
      16: r = {31'h0, x < se};
      17: r = {im, 16'h0};
      18, 21: begin n = (o == 18) ? int'(sh) : int'(x % 32); r = y << n; end
      19, 22: begin n = (o == 19) ? int'(sh) : int'(x % 32); r = y >> n; end
      20, 23: begin n = (o == 20) ? int'(sh) : int'(x % 32); r = 32'($signed(y) >>> n); end
      default: r = 32'h0;
    endcase
  endtask

  task automatic apply_and_check(input int o, input logic [31:0] x, input logic [31:0] y,
                                 input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] er;
    logic ev;
    @(negedge clk);
    op = 5'(o); a = x; b = y; imm = im; shamt = sh;
    #2;
    model(o, x, y, im, sh, er, ev);
    checks++;
    if (result !== er) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d result actual=%h expected=%h",
               res_tag(o), o, x, y, im, sh, result, er);
    end
    checks++;
    if (ovf !== ev) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ovf actual=%b expected=%b",
               (o == 0 || o == 2 || o == 4) ? "R3" : "R4", o, x, y, im, ovf, ev);
    end
  endtask

  initial begin
    av = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h12345678, 32'h00000023, 32'hffffffe1};
    bv = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'hedcba987, 32'h0000ff00, 32'ha5a5a5a5};
    iv = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
    sv = '{5'd0, 5'd1, 5'd15, 5'd31};
    a = '0; b = '0; imm = '0; shamt = '0; op = '0;

    // Idle state: all-zero inputs give zero result and no flag (R2, R4)
    apply_and_check(0, 32'h0, 32'h0, 16'h0, 5'd0);

    // Directed corners
    apply_and_check(0, 32'h7fffffff, 32'h1, 16'h0, 5'd0);          // R3 positive overflow
    apply_and_check(1, 32'h7fffffff, 32'h1, 16'h0, 5'd0);          // R4 unsigned add silent
    apply_and_check(2, 32'h80000000, 32'h1, 16'h0, 5'd0);          // R3 subtract overflow
    apply_and_check(4, 32'h7fffffff, 32'h0, 16'h0001, 5'd0);       // R3 immediate overflow
    apply_and_check(5, 32'h0, 32'h0, 16'hffff, 5'd0);              // R5 ADDIU sign-extends
    apply_and_check(16, 32'h1, 32'h0, 16'hffff, 5'd0);             // R5 SLTIU against 0xffffffff
    apply_and_check(13, 32'hffffffff, 32'h1, 16'h0, 5'd0);         // R7 signed -1 < 1
    apply_and_check(14, 32'hffffffff, 32'h1, 16'h0, 5'd0);         // R7 unsigned not less
    apply_and_check(10, 32'hffffffff, 32'h0, 16'h8000, 5'd0);      // R6 zero-extension
    apply_and_check(17, 32'h0, 32'h0, 16'habcd, 5'd0);             // R8
    apply_and_check(23, 32'hffffffe4, 32'h80000000, 16'h0, 5'd0);  // R10 amount 4 from low bits
    apply_and_check(9, 32'h0f0f0000, 32'h0000f0f0, 16'h0, 5'd0);   // R11 NOR
    apply_and_check(27, 32'hffffffff, 32'hffffffff, 16'hffff, 5'd31); // R12

    // Sweep of every code over the boundary value sets (R1 to R12)
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 6; k++)
            for (int s = 0; s < 4; s++)
              if (s == 0 || (o >= 18 && o <= 20))
                apply_and_check(o, av[i], bv[j], iv[k], sv[s]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule